// File: doc/BRIEF.md
# Width-Converting DMA Byte FIFO with Parity

This block is a sixteen-byte elastic buffer between a 16-bit DMA word bus and an 8-bit SCSI byte stream, and it carries data in either direction. When `dir_to_scsi` is high, the DMA engine writes whole words, and the buffer hands them to the SCSI side one byte at a time. When it is low, bytes taken from the SCSI side are packed in pairs and returned to the DMA engine as words. Each byte on the DMA side has its own parity bit. A mode input selects one of two parity modes. In the generate mode, odd parity is checked on words coming in and regenerated on words going out. In the pass-through mode, the stored bit is delivered unchanged.

`dma_req` is a registered burst request. Toward SCSI it asks for data while at least eight byte slots are free. From SCSI it asks the engine to fetch data once eight bytes are waiting. After an aborted transfer, the `drain` input lets the DMA side pull out the leftover bytes one at a time. Each byte comes out in the low lane, so a trailing odd byte can be recovered. `flush` empties the buffer in a single cycle.

Top module: `dma_width_fifo`

## Requirements
- R1: During and after a reset (synchronous, active high), `fifo_level` is 0, `fifo_empty` is 1, `fifo_full` is 0, `dma_req` is 0 and `par_err` is 0.
- R2: When `dir_to_scsi`=1 and `drain`=0, a `dma_ack` that is accepted stores `dma_wdata[7:0]` first and `dma_wdata[15:8]` second. `scsi_out_valid` is high whenever the buffer holds a byte. `scsi_out_data` shows the oldest byte, and `scsi_out_ready` removes that byte.
- R3: `fifo_full` means the level is 16 and `fifo_empty` means the level is 0. A DMA word write is ignored when the level is above 14. A DMA word read is ignored when the level is below 2. `scsi_in_ready` is low when the buffer is full, and `scsi_out_valid` is low when it is empty.
- R4: When `dir_to_scsi`=0 and `drain`=0, `scsi_in_valid` together with `scsi_in_ready` stores one byte. `dma_rdata` shows the oldest byte in bits 7:0 and the next byte in bits 15:8. An accepted `dma_ack` removes both bytes.
- R5: `dma_req` is registered and reflects the level after the edge, judged with the mode inputs present at that edge. With `drain`=1 it is high while bytes remain. Toward SCSI it is high while the level is at most 8. From SCSI it is high while the level is at least 8.
- R6: With `par_gen`=1, `dma_rpar[i]` is the odd parity of byte lane i, meaning the nine bits together hold an odd number of ones. An incoming word whose `dma_wpar` bit disagrees with odd parity for its lane sets `par_err`. The word is still stored. `par_err` stays set until reset.
- R7: With `par_gen`=0, each incoming parity bit is stored with its byte and returned on `dma_rpar` unchanged, and `par_err` is never set.
- R8: With `drain`=1, each `dma_ack` on a non-empty buffer removes one byte. That byte appears on `dma_rdata[7:0]`, with `dma_rdata[15:8]`=0 and `dma_rpar[1]`=1. While draining, `scsi_in_ready` and `scsi_out_valid` are low.
- R9: `odd_byte` is high exactly when the level is odd.
- R10: `flush` makes the level 0 at the next edge and discards every transfer requested in the same cycle. `par_err` is left unchanged. Data written afterwards is returned in order.
- R11: A word write from DMA and a byte read toward SCSI may happen in the same cycle, and the level then rises by one. A byte write from SCSI and a word read to DMA may happen in the same cycle, and the level then falls by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_to_scsi | input | 1 | 1: DMA words to SCSI bytes; 0: SCSI bytes to DMA words |
| par_gen | input | 1 | 1: generate/check odd parity; 0: carry parity through |
| drain | input | 1 | Leftover byte drain mode for the DMA side |
| flush | input | 1 | Empty the buffer in one cycle |
| dma_ack | input | 1 | DMA word (or drained byte) transfer this cycle |
| dma_wdata | input | 16 | Word written by DMA |
| dma_wpar | input | 2 | Parity bits of the written word, one per byte |
| dma_rdata | output | 16 | Word (or drained byte) offered to DMA |
| dma_rpar | output | 2 | Parity bits of the offered word |
| dma_req | output | 1 | Burst request |
| scsi_in_data | input | 8 | Byte from the SCSI side |
| scsi_in_valid | input | 1 | Byte from SCSI is present |
| scsi_in_ready | output | 1 | Buffer takes a byte from SCSI |
| scsi_out_data | output | 8 | Oldest byte toward SCSI |
| scsi_out_valid | output | 1 | A byte is offered toward SCSI |
| scsi_out_ready | input | 1 | SCSI side takes the offered byte |
| fifo_full | output | 1 | Level equals 16 |
| fifo_empty | output | 1 | Level equals 0 |
| odd_byte | output | 1 | Level is odd |
| par_err | output | 1 | Sticky parity check failure |
| fifo_level | output | 5 | Number of stored bytes |

## Verification
Two pairs of transfers can land on the same edge: a two-byte push from the DMA side with a one-byte pop toward SCSI, and a one-byte push from SCSI with a two-byte pop to the DMA side. The bench holds both strobes high for several consecutive cycles, starting from a mid-range level. It judges the result by the net change of one in the level and by the byte order seen later on the output. A flush asserted together with a DMA acknowledge is also exercised, and the level must read zero afterwards.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  typedef struct packed {
    logic       par;
    logic [7:0] data;
  } dwf_entry_t;

  // odd parity: the returned bit makes the nine bits hold an odd count of ones
  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction
endpackage

// File: rtl/dwf_store.sv
module dwf_store
  import dwf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 2,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic                   clk,
  input  logic [LANES-1:0]       we,
  input  logic [AW-1:0]          wptr,
  input  dwf_entry_t [LANES-1:0] wdat,
  input  logic [AW-1:0]          rptr,
  output dwf_entry_t [LANES-1:0] rdat
);
  dwf_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we[i]) mem[wptr + AW'(i)] <= wdat[i];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) rdat[i] = mem[rptr + AW'(i)];
  end
endmodule

// File: rtl/dwf_ctrl.sv
module dwf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [LW-1:0] push_n,
  input  logic [LW-1:0] pop_n,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nx
);
  always_comb level_nx = flush ? '0 : level + push_n - pop_n;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr + push_n[AW-1:0];
      rptr  <= rptr + pop_n[AW-1:0];
      level <= level_nx;
    end
  end
endmodule

// File: rtl/dwf_lane_par.sv
module dwf_lane_par
  import dwf_pkg::*;
(
  input  logic       [7:0] byte_in,
  input  logic             par_in,
  input  logic             gen_mode,
  output dwf_entry_t       entry_out,
  output logic             err
);
  logic good;
  assign good           = odd_par(byte_in);
  assign entry_out.data = byte_in;
  assign entry_out.par  = gen_mode ? good : par_in;
  assign err            = gen_mode && (par_in != good);
endmodule

// File: rtl/dma_width_fifo.sv
module dma_width_fifo
  import dwf_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DMA_W        = 16,
  parameter int BURST_THRESH = 8
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dir_to_scsi,
  input  logic                   par_gen,
  input  logic                   drain,
  input  logic                   flush,
  input  logic                   dma_ack,
  input  logic [DMA_W-1:0]       dma_wdata,
  input  logic [DMA_W/8-1:0]     dma_wpar,
  output logic [DMA_W-1:0]       dma_rdata,
  output logic [DMA_W/8-1:0]     dma_rpar,
  output logic                   dma_req,
  input  logic [7:0]             scsi_in_data,
  input  logic                   scsi_in_valid,
  output logic                   scsi_in_ready,
  output logic [7:0]             scsi_out_data,
  output logic                   scsi_out_valid,
  input  logic                   scsi_out_ready,
  output logic                   fifo_full,
  output logic                   fifo_empty,
  output logic                   odd_byte,
  output logic                   par_err,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level
);
  localparam int LANES = DMA_W / 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic [AW-1:0]          wptr, rptr;
  logic [LW-1:0]          level, level_nx, push_n, pop_n;
  dwf_entry_t [LANES-1:0] wr_ent, rd_ent, lane_ent;
  logic [LANES-1:0]       lane_err, we;
  logic                   wr_go, rd_go, dr_go, si_go, so_go;

  // level flags
  assign fifo_empty = (level == '0);
  assign fifo_full  = (level == LW'(DEPTH));
  assign odd_byte   = level[0];
  assign fifo_level = level;

  // byte-side handshakes
  assign scsi_in_ready  = !dir_to_scsi && !drain && !fifo_full;
  assign scsi_out_valid = dir_to_scsi && !drain && !fifo_empty;
  assign scsi_out_data  = rd_ent[0].data;

  // accepted transfers this cycle; flush discards all of them
  assign wr_go = dma_ack && !flush && !drain && dir_to_scsi && (level <= LW'(DEPTH - LANES));
  assign rd_go = dma_ack && !flush && !drain && !dir_to_scsi && (level >= LW'(LANES));
  assign dr_go = dma_ack && !flush && drain && !fifo_empty;
  assign si_go = scsi_in_valid && scsi_in_ready && !flush;
  assign so_go = scsi_out_valid && scsi_out_ready && !flush;

  always_comb begin
    push_n = '0;
    if (wr_go)      push_n = LW'(LANES);
    else if (si_go) push_n = LW'(1);
    pop_n = '0;
    if (rd_go)              pop_n = LW'(LANES);
    else if (so_go || dr_go) pop_n = LW'(1);
  end

  // per-lane parity handling, write muxing and read formatting
  for (genvar g = 0; g < LANES; g++) begin : gen_lane
    dwf_lane_par u_par (
      .byte_in  (dma_wdata[8*g +: 8]),
      .par_in   (dma_wpar[g]),
      .gen_mode (par_gen),
      .entry_out(lane_ent[g]),
      .err      (lane_err[g])
    );
    if (g == 0) begin : gen_low
      assign we[g]     = wr_go || si_go;
      assign wr_ent[g] = si_go ? {odd_par(scsi_in_data), scsi_in_data} : lane_ent[g];
      assign dma_rdata[8*g +: 8] = rd_ent[g].data;
      assign dma_rpar[g] = par_gen ? odd_par(rd_ent[g].data) : rd_ent[g].par;
    end else begin : gen_high
      assign we[g]     = wr_go;
      assign wr_ent[g] = lane_ent[g];
      assign dma_rdata[8*g +: 8] = drain ? 8'h00 : rd_ent[g].data;
      assign dma_rpar[g] = drain ? 1'b1
                         : (par_gen ? odd_par(rd_ent[g].data) : rd_ent[g].par);
    end
  end

  dwf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .push_n  (push_n),
    .pop_n   (pop_n),
    .wptr    (wptr),
    .rptr    (rptr),
    .level   (level),
    .level_nx(level_nx)
  );

  dwf_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk (clk),
    .we  (we),
    .wptr(wptr),
    .wdat(wr_ent),
    .rptr(rptr),
    .rdat(rd_ent)
  );

  always_ff @(posedge clk) begin
    if (rst) par_err <= 1'b0;
    else if (wr_go && |lane_err) par_err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)              dma_req <= 1'b0;
    else if (drain)       dma_req <= (level_nx != '0);
    else if (dir_to_scsi) dma_req <= (level_nx <= LW'(DEPTH - BURST_THRESH));
    else                  dma_req <= (level_nx >= LW'(BURST_THRESH));
  end
endmodule

// File: rtl/dwf_checker.sv
module dwf_checker #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
)(
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          drain,
  input logic          dir_to_scsi,
  input logic          par_gen,
  input logic          dma_ack,
  input logic          scsi_out_ready,
  input logic [LW-1:0] fifo_level,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          scsi_in_ready,
  input logic          scsi_out_valid,
  input logic          par_err
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));

  assert_full_blocks_in_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !scsi_in_ready);

  assert_empty_no_out_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !scsi_out_valid);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);

  assert_pass_no_err_R7: assert property (@(posedge clk) disable iff (rst)
    (!par_gen && !par_err) |=> !par_err);

  assert_drain_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    drain |-> (!scsi_in_ready && !scsi_out_valid));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> fifo_empty);

  assert_concurrent_R11: assert property (@(posedge clk) disable iff (rst)
    (dir_to_scsi && !drain && !flush && dma_ack && scsi_out_ready &&
     fifo_level >= LW'(1) && fifo_level <= LW'(DEPTH - 2))
    |=> (fifo_level == $past(fifo_level) + LW'(1)));
endmodule

bind dma_width_fifo dwf_checker #(.DEPTH(DEPTH)) u_dwf_checker (
  .clk           (clk),
  .rst           (rst),
  .flush         (flush),
  .drain         (drain),
  .dir_to_scsi   (dir_to_scsi),
  .par_gen       (par_gen),
  .dma_ack       (dma_ack),
  .scsi_out_ready(scsi_out_ready),
  .fifo_level    (fifo_level),
  .fifo_full     (fifo_full),
  .fifo_empty    (fifo_empty),
  .scsi_in_ready (scsi_in_ready),
  .scsi_out_valid(scsi_out_valid),
  .par_err       (par_err)
);

// File: tb/tb_dma_width_fifo.sv
module tb_dma_width_fifo;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, dir = 1'b1, gen = 1'b1, drain = 1'b0, flush = 1'b0;
  logic dma_ack = 1'b0;
  logic [15:0] dma_wdata = '0, dma_rdata;
  logic [1:0]  dma_wpar = '0, dma_rpar;
  logic dma_req;
  logic [7:0] scsi_in_data = '0, scsi_out_data;
  logic scsi_in_valid = 1'b0, scsi_in_ready, scsi_out_valid, scsi_out_ready = 1'b0;
  logic fifo_full, fifo_empty, odd_byte, par_err;
  logic [4:0] fifo_level;

  dma_width_fifo dut (
    .clk(clk), .rst(rst), .dir_to_scsi(dir), .par_gen(gen), .drain(drain),
    .flush(flush), .dma_ack(dma_ack), .dma_wdata(dma_wdata), .dma_wpar(dma_wpar),
    .dma_rdata(dma_rdata), .dma_rpar(dma_rpar), .dma_req(dma_req),
    .scsi_in_data(scsi_in_data), .scsi_in_valid(scsi_in_valid),
    .scsi_in_ready(scsi_in_ready), .scsi_out_data(scsi_out_data),
    .scsi_out_valid(scsi_out_valid), .scsi_out_ready(scsi_out_ready),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .odd_byte(odd_byte),
    .par_err(par_err), .fifo_level(fifo_level)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [8:0] q[$];
  bit exp_err = 0, exp_req = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic op(input logic [7:0] b);
    return (($countones(b) % 2) == 0);
  endfunction

  task automatic check_state();
    chk("R3 level", fifo_level, q.size());
    chk("R3 full", fifo_full, q.size() == 16);
    chk("R3 empty", fifo_empty, q.size() == 0);
    chk("R9 odd", odd_byte, q.size() % 2);
    chk("R6 err", par_err, exp_err);
    chk("R5 req", dma_req, exp_req);
    chk("R3 sin_ready", scsi_in_ready, !dir && !drain && q.size() < 16);
    chk("R2 sout_valid", scsi_out_valid, dir && !drain && q.size() > 0);
  endtask

  task automatic cycle(input bit ack, input logic [15:0] wd, input logic [1:0] wp,
                       input bit siv, input logic [7:0] sid, input bit sor, input bit fl);
    int n;
    bit wr, rd, dr, si, so;
    logic [7:0] b;
    n  = q.size();
    wr = ack && !fl && !drain && dir && n <= 14;
    rd = ack && !fl && !drain && !dir && n >= 2;
    dr = ack && !fl && drain && n > 0;
    si = siv && !fl && !dir && !drain && n < 16;
    so = sor && !fl && dir && !drain && n > 0;
    dma_ack = ack; dma_wdata = wd; dma_wpar = wp;
    scsi_in_valid = siv; scsi_in_data = sid; scsi_out_ready = sor; flush = fl;
    #1;
    if (so) chk("R2 sout_data", scsi_out_data, q[0][7:0]);
    if (rd) begin
      chk("R4 rdata", dma_rdata, {q[1][7:0], q[0][7:0]});
      chk(gen ? "R6 rpar" : "R7 rpar", dma_rpar,
          {gen ? op(q[1][7:0]) : q[1][8], gen ? op(q[0][7:0]) : q[0][8]});
    end
    if (dr) begin
      chk("R8 drain_data", dma_rdata, {8'h00, q[0][7:0]});
      chk(gen ? "R8 drain_par" : "R7 drain_par", dma_rpar,
          {1'b1, gen ? op(q[0][7:0]) : q[0][8]});
    end
    if (fl) q.delete();
    else begin
      if (rd) begin void'(q.pop_front()); void'(q.pop_front()); end
      if (so || dr) void'(q.pop_front());
      if (wr) for (int i = 0; i < 2; i++) begin
        b = wd[8*i +: 8];
        q.push_back({gen ? op(b) : wp[i], b});
        if (gen && wp[i] != op(b)) exp_err = 1;
      end
      if (si) q.push_back({op(sid), sid});
    end
    exp_req = drain ? (q.size() != 0) : dir ? (q.size() <= 8) : (q.size() >= 8);
    @(posedge clk); #1;
    dma_ack = 0; scsi_in_valid = 0; scsi_out_ready = 0; flush = 0;
    check_state();
  endtask

  function automatic logic [15:0] wordk(input int k);
    return {8'(k * 29 + 64), 8'(k * 13 + 3)};
  endfunction

  function automatic logic [1:0] goodp(input logic [15:0] w);
    return {op(w[15:8]), op(w[7:0])};
  endfunction

  task automatic do_reset();
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    q.delete(); exp_err = 0; exp_req = 0;
    chk("R1 level", fifo_level, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 req", dma_req, 0);
    chk("R1 err", par_err, 0);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev;
    do_reset();
    // toward SCSI: fill past capacity, then empty past zero (R2 R3 R5)
    dir = 1; gen = 1;
    cycle(0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 9; k++) cycle(1, wordk(k), goodp(wordk(k)), 0, 0, 0, 0);
    for (int k = 0; k < 17; k++) cycle(0, 0, 0, 0, 0, 1, 0);
    // concurrent word write and byte read (R11)
    for (int k = 0; k < 2; k++) cycle(1, wordk(k + 20), goodp(wordk(k + 20)), 0, 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      prev = fifo_level;
      cycle(1, wordk(k + 30), goodp(wordk(k + 30)), 0, 0, 1, 0);
      chk("R11 up", fifo_level, prev + 1);
    end
    for (int k = 0; k < 12; k++) cycle(0, 0, 0, 0, 0, 1, 0);
    // from SCSI: fill past capacity, read words past empty (R4 R3 R5 R9)
    dir = 0;
    cycle(0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 17; k++) cycle(0, 0, 0, 1, 8'(k * 37 + 1), 0, 0);
    for (int k = 0; k < 9; k++) cycle(1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) cycle(0, 0, 0, 1, 8'(k * 11 + 90), 0, 0);
    for (int k = 0; k < 3; k++) begin
      prev = fifo_level;
      cycle(1, 0, 0, 1, 8'(k * 5 + 200), 0, 0);
      chk("R11 down", fifo_level, prev - 1);
    end
    cycle(1, 0, 0, 0, 0, 0, 0);
    // parity check failure, then flush with a same-cycle ack (R6 R10)
    dir = 1;
    cycle(1, 16'h3C5A, goodp(16'h3C5A) ^ 2'b10, 0, 0, 0, 0);
    chk("R6 err set", par_err, 1);
    cycle(1, wordk(50), goodp(wordk(50)), 0, 0, 0, 0);
    cycle(1, wordk(51), goodp(wordk(51)), 0, 0, 0, 1);
    chk("R10 level", fifo_level, 0);
    chk("R10 err kept", par_err, 1);
    cycle(1, wordk(52), goodp(wordk(52)), 0, 0, 0, 0);
    for (int k = 0; k < 2; k++) cycle(0, 0, 0, 0, 0, 1, 0);
    // pass-through parity and drain (R7 R8)
    do_reset();
    gen = 0; dir = 1;
    for (int k = 0; k < 4; k++) cycle(1, wordk(k + 60), 2'(k), 0, 0, 0, 0);
    chk("R7 no err", par_err, 0);
    drain = 1;
    cycle(0, 0, 0, 0, 0, 0, 0);
    chk("R8 quiet", scsi_out_valid, 0);
    for (int k = 0; k < 9; k++) cycle(1, 0, 0, 0, 0, 0, 0);
    drain = 0;
    // odd trailing byte recovered by drain (R9 R8)
    gen = 1;
    for (int k = 0; k < 2; k++) cycle(1, wordk(k + 70), goodp(wordk(k + 70)), 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cycle(0, 0, 0, 0, 0, 1, 0);
    chk("R9 odd left", odd_byte, 1);
    drain = 1;
    cycle(0, 0, 0, 0, 0, 1, 0);
    chk("R8 req on leftover", dma_req, 1);
    cycle(1, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, 0);
    drain = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule